// File: doc/BRIEF.md
# Pointer-Based Sequential RAM Port

This block gives a host a narrow window onto a 2048-byte packet buffer, arranged as eight 256-byte pages. The host never drives a RAM address. It loads an 11-bit pointer through two pointer registers, then moves bytes one at a time through a single data register. The upper pointer register also carries two control flags. One selects the read direction. The other makes the pointer advance by one after every data access, so a whole packet can be streamed as a burst.

In read direction, a write to the lower pointer register starts a fetch of the addressed byte into the data register. After that, each data read that advances the pointer fetches the byte at the new address. The host therefore always finds the next byte waiting and never has to insert a dummy read.

The fetch is run by a three-state machine. FS_IDLE moves to FS_FETCH on a fetch trigger. FS_FETCH issues the RAM read and moves to FS_LOAD, or stays in FS_FETCH if a new trigger arrives. FS_LOAD copies the RAM output into the data register and moves to FS_IDLE, or to FS_FETCH on a trigger.

Top module: `seq_ram_port`

## Requirements
- R1: After reset, the pointer is 0, both flags are clear and the data register is 0, so every register reads 0x00.
- R2: Register address 0 is the upper pointer register. Bit 7 is the read-direction flag, bit 6 is the auto-advance flag, and bits 2:0 are pointer bits 10:8. It reads back what was written to those bits.
- R3: Bits 5:3 of the upper pointer register always read 0 and ignore writes. Register addresses 3 to 7 read 0x00, and writes to them have no effect.
- R4: Register address 1 is the lower pointer register. It holds pointer bits 7:0 and reads back the last value written or reached.
- R5: A write to the data register (address 2) with the read flag clear stores the byte at the pointer. With the read flag set, the write is ignored: neither the RAM nor the pointer changes.
- R6: With the auto-advance flag set, the pointer increments by one after each data read and after each data write that is not ignored. With the flag clear, data accesses leave the pointer unchanged.
- R7: An increment from pointer value 2047 wraps the pointer to 0.
- R8: Writing the lower pointer register while the read flag is set loads the byte at the new pointer into the data register within two clock cycles.
- R9: A data read with both flags set returns the prefetched byte, then loads the byte at the incremented pointer within two clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select for a register access |
| rd | input | 1 | Read strobe, one cycle per access |
| wr | input | 1 | Write strobe, one cycle per access |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data; valid while cs and rd are high, 0x00 otherwise |

## Verification
The bench first fills the whole buffer in one auto-advancing burst that runs from address 0 to the end. This catches a pointer that saturates or spills into a wrong page at 2047 instead of wrapping to 0. Data writes in read direction are checked through the pointer and a later read-back; a design that accepted them would corrupt the buffer or move the pointer. A read taken right after a lower-pointer write, or right after an advancing read, exposes a missing or late fetch: the design would return the previous byte. Random mixes of flag settings, pointer loads and accesses then check that the upper and lower pointer registers stay consistent, and that the reserved bits stay zero.

// File: rtl/seq_ram_pkg.sv
package seq_ram_pkg;
    localparam logic [2:0] REG_PTR_HI = 3'd0;
    localparam logic [2:0] REG_PTR_LO = 3'd1;
    localparam logic [2:0] REG_DATA   = 3'd2;

    localparam int FLAG_RD_BIT  = 7;
    localparam int FLAG_INC_BIT = 6;

    typedef enum logic [1:0] {
        FS_IDLE  = 2'd0,
        FS_FETCH = 2'd1,
        FS_LOAD  = 2'd2
    } fetch_st_e;
endpackage

// File: rtl/seq_ram_mem.sv
module seq_ram_mem #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic [AW-1:0] a,
    input  logic          we,
    input  logic [DW-1:0] wd,
    input  logic          re,
    output logic [DW-1:0] q
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store[a] <= wd;
        end
        if (re) begin
            q <= store[a];
        end
    end
endmodule

// File: rtl/seq_ram_ptr.sv
module seq_ram_ptr
    import seq_ram_pkg::*;
#(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hi_we,
    input  logic          lo_we,
    input  logic [7:0]    wd,
    input  logic          step,
    output logic [AW-1:0] ptr,
    output logic          rd_flag,
    output logic          inc_flag
);
    localparam int HI_W = AW - 8;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr      <= '0;
            rd_flag  <= 1'b0;
            inc_flag <= 1'b0;
        end else if (hi_we) begin
            rd_flag       <= wd[FLAG_RD_BIT];
            inc_flag      <= wd[FLAG_INC_BIT];
            ptr[AW-1:8]   <= wd[HI_W-1:0];
        end else if (lo_we) begin
            ptr[7:0] <= wd;
        end else if (step) begin
            ptr <= AW'(ptr + 1'b1);
        end
    end

    // An advancing access moves the pointer by exactly one, wrapping at the top
    assert_ptr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        step && !hi_we && !lo_we |=> ptr == AW'($past(ptr) + 1'b1));

    // No register access and no advance: the pointer holds
    assert_ptr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !step && !hi_we && !lo_we |=> $stable(ptr));
endmodule

// File: rtl/seq_ram_fetch.sv
module seq_ram_fetch
    import seq_ram_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trigger,
    input  logic [DW-1:0] ram_q,
    output logic          ram_re,
    output logic [DW-1:0] dreg
);
    fetch_st_e st, st_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= FS_IDLE;
        end else begin
            st <= st_nx;
        end
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            FS_IDLE:  st_nx = trigger ? FS_FETCH : FS_IDLE;
            FS_FETCH: st_nx = trigger ? FS_FETCH : FS_LOAD;
            FS_LOAD:  st_nx = trigger ? FS_FETCH : FS_IDLE;
            default:  st_nx = FS_IDLE;
        endcase
    end

    assign ram_re = (st == FS_FETCH);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dreg <= '0;
        end else if (st == FS_LOAD) begin
            dreg <= ram_q;
        end
    end

    // A fetch trigger always issues a RAM read on the next cycle
    assert_fetch_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        trigger |=> ram_re);

    // A read lasts one cycle unless it is retriggered
    assert_fetch_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ram_re |=> !ram_re || $past(trigger));

    // The data register only changes on the load step
    assert_dreg_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st != FS_LOAD) |=> $stable(dreg));
endmodule

// File: rtl/seq_ram_port.sv
module seq_ram_port
    import seq_ram_pkg::*;
#(
    parameter int AW = 11
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs,
    input  logic       rd,
    input  logic       wr,
    input  logic [2:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata
);
    localparam int HI_W = AW - 8;
    localparam int RSV_W = 6 - HI_W;

    logic [AW-1:0] ptr;
    logic          rd_flag, inc_flag;
    logic          ram_re, ram_we;
    logic [7:0]    ram_q, dreg;
    logic          hi_we, lo_we, data_rd, data_wr, step, trigger;

    assign hi_we   = cs && wr && (addr == REG_PTR_HI);
    assign lo_we   = cs && wr && (addr == REG_PTR_LO);
    assign data_rd = cs && rd && (addr == REG_DATA);
    assign data_wr = cs && wr && (addr == REG_DATA) && !rd_flag;
    assign ram_we  = data_wr;
    assign step    = inc_flag && (data_rd || data_wr);
    assign trigger = rd_flag && (lo_we || (data_rd && inc_flag));

    seq_ram_ptr #(.AW(AW)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .hi_we    (hi_we),
        .lo_we    (lo_we),
        .wd       (wdata),
        .step     (step),
        .ptr      (ptr),
        .rd_flag  (rd_flag),
        .inc_flag (inc_flag)
    );

    seq_ram_mem #(.AW(AW), .DW(8)) u_mem (
        .clk (clk),
        .a   (ptr),
        .we  (ram_we),
        .wd  (wdata),
        .re  (ram_re),
        .q   (ram_q)
    );

    seq_ram_fetch #(.DW(8)) u_fetch (
        .clk     (clk),
        .rst_n   (rst_n),
        .trigger (trigger),
        .ram_q   (ram_q),
        .ram_re  (ram_re),
        .dreg    (dreg)
    );

    always_comb begin
        rdata = 8'h00;
        if (cs && rd) begin
            unique case (addr)
                REG_PTR_HI: rdata = {rd_flag, inc_flag, {RSV_W{1'b0}}, ptr[AW-1:8]};
                REG_PTR_LO: rdata = ptr[7:0];
                REG_DATA:   rdata = dreg;
                default:    rdata = 8'h00;
            endcase
        end
    end

    // Reserved bits of the upper pointer register never read as one
    assert_rsv_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cs && rd && (addr == REG_PTR_HI) |-> rdata[5:3] == 3'b000);

    // The RAM is never written while the port is in read direction
    assert_no_rd_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> !rd_flag);

    // The RAM read and write are never issued in the same cycle
    assert_one_ram_op_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ram_we, ram_re}));
endmodule

// File: tb/seq_ram_port_test.sv
module seq_ram_port_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs = 1'b0, rd = 1'b0, wr = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [7:0]  mem [2048];
    logic [10:0] m_ptr = '0;
    logic        m_rdf = 1'b0, m_inc = 1'b0;
    logic [7:0]  m_dreg = 8'h00;

    always #4 clk = ~clk;

    seq_ram_port uut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr),
        .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    task automatic check(input logic ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_reg(input logic [2:0] a);
        case (a)
            3'd0: return {m_rdf, m_inc, 3'b000, m_ptr[10:8]};
            3'd1: return m_ptr[7:0];
            3'd2: return m_dreg;
            default: return 8'h00;
        endcase
    endfunction

    task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        cs = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        cs = 1'b0; wr = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        cs = 1'b1; rd = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        cs = 1'b0; rd = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // Write with model update (R2, R3, R4, R5, R6, R8)
    task automatic do_wr(input logic [2:0] a, input logic [7:0] d);
        bus_wr(a, d);
        case (a)
            3'd0: begin m_rdf = d[7]; m_inc = d[6]; m_ptr[10:8] = d[2:0]; end
            3'd1: begin m_ptr[7:0] = d; if (m_rdf) m_dreg = mem[m_ptr]; end
            3'd2: if (!m_rdf) begin mem[m_ptr] = d; if (m_inc) m_ptr = m_ptr + 11'd1; end
            default: ;
        endcase
    endtask

    // Read with comparison and model update (R9 on data reads)
    task automatic do_rd(input logic [2:0] a, input string req);
        logic [7:0] got, exp;
        exp = exp_reg(a);
        bus_rd(a, got);
        check(got === exp, req, got, exp);
        if (a == 3'd2 && m_inc) begin
            m_ptr = m_ptr + 11'd1;
            if (m_rdf) m_dreg = mem[m_ptr];
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got 00 expected 01");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        for (int a = 0; a < 3; a++) do_rd(3'(a), "R1");

        // R3: reserved bits and unmapped addresses
        do_wr(3'd0, 8'h38);
        do_rd(3'd0, "R3");
        do_wr(3'd5, 8'hFF);
        do_rd(3'd5, "R3");
        do_rd(3'd0, "R3");

        // R6/R7: fill the whole buffer in one auto-advancing burst, ending in a wrap
        do_wr(3'd0, 8'h40);
        do_wr(3'd1, 8'h00);
        for (int i = 0; i < 2048; i++) do_wr(3'd2, 8'($urandom));
        do_rd(3'd1, "R7");
        do_rd(3'd0, "R7");

        // R7: single step from the top address
        do_wr(3'd0, 8'h47);
        do_wr(3'd1, 8'hFF);
        do_wr(3'd2, 8'hA5);
        do_rd(3'd0, "R7");
        do_rd(3'd1, "R7");

        // R8/R9: pointer load in read direction, then back-to-back advancing reads across the top
        do_wr(3'd0, 8'hC7);
        do_wr(3'd1, 8'hFE);
        for (int i = 0; i < 4; i++) do_rd(3'd2, "R9");
        do_rd(3'd1, "R9");

        // R5: data write in read direction is ignored
        do_wr(3'd0, 8'h83);
        do_wr(3'd1, 8'h10);
        do_wr(3'd2, ~mem[11'h310]);
        do_rd(3'd1, "R5");
        do_wr(3'd1, 8'h10);
        do_rd(3'd2, "R5");

        // R6: no advance with the flag clear
        do_wr(3'd0, 8'h02);
        do_wr(3'd1, 8'h33);
        do_wr(3'd2, 8'h5A);
        do_rd(3'd2, "R6");
        do_rd(3'd1, "R6");

        // Random mix (R2, R4, R5, R6, R8, R9)
        for (int i = 0; i < 400; i++) begin
            int unsigned op = $urandom % 6;
            case (op)
                0: do_wr(3'd0, 8'($urandom));
                1: do_wr(3'd1, 8'($urandom));
                2: do_wr(3'd2, 8'($urandom));
                3: do_rd(3'd2, "R9");
                4: do_rd(3'd0, "R2");
                default: do_rd(3'd1, "R4");
            endcase
        end

        // Final read-back of a few locations through the port (R5, R8)
        do_wr(3'd0, 8'hC0);
        for (int i = 0; i < 8; i++) begin
            v = 8'($urandom);
            do_wr(3'd0, {2'b11, 3'b000, 3'(v)});
            do_wr(3'd1, 8'($urandom));
            do_rd(3'd2, "R8");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule